// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address that a synchronous memory port uses in each cycle. At every rising clock edge it chooses one of four sources: zero, a new address taken from the external bus, the address used in the previous cycle plus one, or the previous address unchanged. The chosen value is registered, and that registered value is the address for the access made in that cycle.

Bursts need only one external address. The caller strobes in a start address and then pulses the step control to walk through consecutive locations. The caller can pause the walk by leaving all controls inactive, or return to location zero without losing a cycle. The block has no chip-enable input, so its controls act whether or not the memory access behind it is enabled.

Top module: `burst_addr_gen`

## Requirements
- R1: When `clr_n_i` is low at a rising edge, `addr_o` is zero after that edge. This holds whatever levels `strobe_n_i` and `step_n_i` have.
- R2: When `clr_n_i` is high and `strobe_n_i` is low at a rising edge, `addr_o` after that edge equals the `ext_addr_i` value sampled at that edge. This holds whatever level `step_n_i` has.
- R3: When `clr_n_i` and `strobe_n_i` are high and `step_n_i` is low at a rising edge, `addr_o` after that edge is its previous value plus one. The incremented value is the address of that same cycle.
- R4: When `clr_n_i`, `strobe_n_i` and `step_n_i` are all high at a rising edge, `addr_o` keeps its value.
- R5: A step from the all-ones address (2^ADDR_W - 1) gives zero.
- R6: When `rst_n` is low at a rising edge, `addr_o` is zero after that edge. This takes priority over every control input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| ext_addr_i | input | ADDR_W | External start address |
| strobe_n_i | input | 1 | Active-low load of the external address |
| step_n_i | input | 1 | Active-low advance by one |
| clr_n_i | input | 1 | Active-low return to zero |
| addr_o | output | ADDR_W | Address for the current cycle |

## Verification
The block holds a single register, and that register is `addr_o`. A wrong internal state therefore shows at the port in the first cycle after the edge that produced it. It also spreads into every following step or hold until a load, clear or reset overwrites it. A wrong priority among the controls gives a mismatch at once in the cycles where two or more controls are low together. A carry error shows at the wrap from all-ones to zero. For these reasons the bench compares `addr_o` after every edge, against a model that applies the four sources in priority order.

// File: rtl/burst_addr_pkg.sv
// Shared types for the burst address generator.
package burst_addr_pkg;
    // Source of the next cycle's address, in the order that priority is resolved.
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_STEP = 2'd1,
        SRC_LOAD = 2'd2,
        SRC_ZERO = 2'd3
    } addr_src_e;
endpackage

// File: rtl/burst_addr_select.sv
// Priority decoder for the address source.
// Assumes active-low controls. Clear outranks load, and load outranks step.
module burst_addr_select
    import burst_addr_pkg::*;
(
    input  logic      clr_n_i,
    input  logic      strobe_n_i,
    input  logic      step_n_i,
    output addr_src_e src_o
);
    // Resolve the controls into exactly one source.
    always_comb begin
        if (!clr_n_i)         src_o = SRC_ZERO;
        else if (!strobe_n_i) src_o = SRC_LOAD;
        else if (!step_n_i)   src_o = SRC_STEP;
        else                  src_o = SRC_HOLD;
    end
endmodule

// File: rtl/burst_addr_incr.sv
// Modulo-2^W incrementer. It assumes wrap-around is wanted, so the carry out is dropped.
module burst_addr_incr #(
    parameter int W = 14
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] y_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Add one within W bits.
    always_comb y_o = a_i + ONE;
endmodule

// File: rtl/burst_addr_reg.sv
// Address register with a four-way source mux.
// Assumes a synchronous active-low reset that clears the register to zero.
module burst_addr_reg
    import burst_addr_pkg::*;
#(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  addr_src_e    src_i,
    input  logic [W-1:0] ext_i,
    input  logic [W-1:0] inc_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] d;

    // Select the value to load at the next edge.
    always_comb begin
        unique case (src_i)
            SRC_ZERO: d = '0;
            SRC_LOAD: d = ext_i;
            SRC_STEP: d = inc_i;
            default:  d = q_o;
        endcase
    end

    // Store the address for the current cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d;
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Burst address generator, top level.
// Each edge registers one of: zero, the external address, the previous address
// plus one, or the previous address. No chip-enable input gates the controls.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr_i,
    input  logic              strobe_n_i,
    input  logic              step_n_i,
    input  logic              clr_n_i,
    output logic [ADDR_W-1:0] addr_o
);
    addr_src_e         src;
    logic [ADDR_W-1:0] inc;

    burst_addr_select u_sel (
        .clr_n_i   (clr_n_i),
        .strobe_n_i(strobe_n_i),
        .step_n_i  (step_n_i),
        .src_o     (src)
    );

    burst_addr_incr #(.W(ADDR_W)) u_inc (
        .a_i(addr_o),
        .y_o(inc)
    );

    burst_addr_reg #(.W(ADDR_W)) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .src_i(src),
        .ext_i(ext_addr_i),
        .inc_i(inc),
        .q_o  (addr_o)
    );
endmodule

// File: rtl/burst_addr_gen_chk.sv
// Port-level checker for burst_addr_gen. It is attached to the top module by the bind below.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr_i,
    input logic              strobe_n_i,
    input logic              step_n_i,
    input logic              clr_n_i,
    input logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_i |=> addr_o == '0); // R1

    AST_LOAD_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_i && !strobe_n_i) |=> addr_o == $past(ext_addr_i)); // R2

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_i && strobe_n_i && !step_n_i) |=> addr_o == ADDR_W'($past(addr_o) + 1'b1)); // R3

    AST_HOLD_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_i && strobe_n_i && step_n_i) |=> $stable(addr_o)); // R4

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_i && strobe_n_i && !step_n_i && addr_o == TOP) |=> addr_o == '0); // R5
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr_i(ext_addr_i),
    .strobe_n_i(strobe_n_i),
    .step_n_i  (step_n_i),
    .clr_n_i   (clr_n_i),
    .addr_o    (addr_o)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
    localparam int          ADDR_W = 14;
    localparam int          CLK_PERIOD = 10;
    localparam logic [ADDR_W-1:0] TOP = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] ext_addr = '0;
    logic              strobe_n = 1'b1;
    logic              step_n = 1'b1;
    logic              clr_n = 1'b1;
    logic [ADDR_W-1:0] addr;

    int                tests = 0;
    int                fails = 0;
    logic [ADDR_W-1:0] exp_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_addr_i(ext_addr),
        .strobe_n_i(strobe_n),
        .step_n_i  (step_n),
        .clr_n_i   (clr_n),
        .addr_o    (addr)
    );

    // Reference model: the next address under the priority stated in R6, R1..R4.
    function automatic logic [ADDR_W-1:0] model(input logic rs, input logic c, input logic s,
                                                input logic st, input logic [ADDR_W-1:0] ext,
                                                input logic [ADDR_W-1:0] prev);
        if (!rs)     return '0;
        if (!c)      return '0;
        if (!s)      return ext;
        if (!st)     return prev + 1'b1;
        return prev;
    endfunction

    function automatic string req_of(input logic rs, input logic c, input logic s,
                                     input logic st, input logic [ADDR_W-1:0] prev);
        if (!rs)                 return "R6";
        if (!c)                  return "R1";
        if (!s)                  return "R2";
        if (!st && prev == TOP)  return "R5";
        if (!st)                 return "R3";
        return "R4";
    endfunction

    // Drives one cycle from a falling edge and checks addr_o at the next falling edge.
    task automatic cycle(input logic rs, input logic c, input logic s, input logic st,
                         input logic [ADDR_W-1:0] ext);
        string r;
        rst_n = rs; clr_n = c; strobe_n = s; step_n = st; ext_addr = ext;
        r = req_of(rs, c, s, st, exp_addr);
        @(posedge clk);
        exp_addr = model(rs, c, s, st, ext, exp_addr);
        @(negedge clk);
        tests++;
        if (addr !== exp_addr) begin
            fails++;
            $display("FAIL %s: addr=%0h expected=%0h", r, addr, exp_addr);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        cycle(0, 1, 1, 1, 14'h1234);            // R6 reset state
        cycle(0, 1, 0, 0, 14'h0ABC);            // R6 outranks load
        cycle(1, 1, 0, 1, 14'h0005);            // R2 load
        cycle(1, 1, 1, 0, 14'h3FFF);            // R3 step, ext ignored
        cycle(1, 1, 1, 1, 14'h2222);            // R4 hold
        cycle(1, 1, 0, 0, 14'h0100);            // R2 load outranks step
        cycle(1, 0, 0, 1, 14'h0777);            // R1 clear outranks load
        cycle(1, 1, 1, 0, 14'h0000);            // R3 step from zero -> 1
        cycle(1, 0, 1, 0, 14'h0000);            // R1 clear outranks step
        cycle(1, 1, 0, 1, TOP);                 // R2 load all-ones
        cycle(1, 1, 1, 0, 14'h0000);            // R5 wrap to zero
        cycle(1, 1, 0, 1, 14'h0042);
        cycle(1, 0, 0, 0, 14'h1111);            // R1 all controls low
        for (int i = 0; i < 3000; i++) begin
            logic [ADDR_W-1:0] e;
            logic rs;
            rs = ($urandom % 50) != 0;
            e  = ($urandom % 8 == 0) ? TOP - ADDR_W'($urandom % 3) : ADDR_W'($urandom);
            cycle(rs, ($urandom % 6) != 0, ($urandom % 3) != 0, $urandom % 2 == 0 ? 1'b0 : 1'b1, e);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule